// File: doc/BRIEF.md
# SPI-Driven NAND Bus and Board Control Bridge

This block is an SPI target (clock idle low, sampled on the rising edge, shifted on the falling edge) that gives a host processor byte-level control of a raw 8-bit NAND flash bus and a few board outputs. The serial lines are brought into the system clock domain by synchronizer chains and oversampled. Each chip-select frame opens with a command byte, most significant bit first. The command byte decides what the rest of the frame means.

There are five uses for a frame. It can load a control byte that drives four indicator lamps, a fan enable and the NAND latch-enable and chip-enable pins. It can switch a fifth, separate lamp on or off. It can push a stream of bytes onto the NAND data pins with write strobes. It can pull bytes back with read strobes, after either a short or a long turnaround. Strobe widths are counted in system clocks. The NAND data pins are driven only while a write cycle is in progress.

Top module: `spi_nand_bridge`

## Requirements
- R1: After reset the control byte is 0x80: all four lamps, the fan and both latch enables are low, the NAND chip enable (active low) is high, the separate lamp is off, both strobes are high and the data pins are not driven.
- R2: Command 0x09 copies every later byte of the frame into the control byte, so the last byte wins. Bits 3..0 drive lamps 4..1, bit 4 the fan enable, bit 5 the address latch enable, bit 6 the command latch enable and bit 7 the active-low chip enable.
- R3: Command 0x0C turns the separate lamp on and 0x0D turns it off. Any later bytes in those frames change nothing.
- R4: After command 0x08, each received byte is written to the NAND bus once the next byte of the frame has arrived, in arrival order. The last byte before chip select rises (the host's closing idle byte) is never written.
- R5: Every write strobe stays low for at least WE_LOW_CYCLES system clocks. The data pins are driven and stable from before the strobe falls until after it rises.
- R6: Command 0x0A takes one turnaround byte. One read strobe then fetches a byte that is returned on MISO, MSB first, during the next byte of the frame, and each returned byte triggers one more read strobe. No read strobe occurs before the turnaround byte has completed.
- R7: Command 0x0B works the same way but takes four turnaround bytes. No read strobe occurs after only three of them.
- R8: The data pins are driven only inside a write cycle, and the two strobes are never low at the same time.
- R9: After an unrecognized command byte, the rest of the frame is ignored: no control, lamp or strobe activity until chip select rises.
- R10: Raising chip select drops any partly shifted byte and returns decoding to the command byte for the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Frame select from the host, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| nand_data_i | input | 8 | NAND data pins, input side |
| nand_data_o | output | 8 | NAND data pins, output side |
| nand_data_oe | output | 1 | Output enable for the NAND data pins |
| nand_we_n | output | 1 | NAND write strobe, active low |
| nand_re_n | output | 1 | NAND read strobe, active low |
| nand_ale | output | 1 | NAND address latch enable |
| nand_cle | output | 1 | NAND command latch enable |
| nand_ce_n | output | 1 | NAND chip enable, active low |
| led_o | output | 4 | Indicator lamps 1 to 4 |
| fan_en | output | 1 | Fan enable |
| led_aux | output | 1 | Separate fifth lamp |

## Verification
Control bytes come from a vector table whose entries each light a single field, plus mixed patterns, so a swapped or shifted bit position shows up at the pins. The write stream is tested with several data bytes and a closing idle byte, which separates one-byte-delayed writing from writing every byte. Both read commands are stopped one turnaround byte short, which separates the one-byte and four-byte turnarounds. Unknown commands followed by valid command values, and a frame cut off after five bits, show whether the decoder really resynchronizes only on chip select.

// File: rtl/spi_nand_pkg.sv
package spi_nand_pkg;

  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [7:0] {
    OP_NAND_WR      = 8'h08,
    OP_CFG_WR       = 8'h09,
    OP_NAND_RD      = 8'h0A,
    OP_NAND_RD_FAST = 8'h0B,
    OP_AUX_ON       = 8'h0C,
    OP_AUX_OFF      = 8'h0D
  } opcode_e;

  // control byte layout
  localparam int unsigned CTL_LAMP_LO = 0;
  localparam int unsigned CTL_LAMP_N  = 4;
  localparam int unsigned CTL_FAN     = 4;
  localparam int unsigned CTL_ALE     = 5;
  localparam int unsigned CTL_CLE     = 6;
  localparam int unsigned CTL_CE_N    = 7;
  localparam byte_t       CTL_RESET   = 8'h80;

  localparam int unsigned TURN_W = 3;

  typedef enum logic [2:0] {
    DEC_OPCODE, DEC_CFG, DEC_WRITE, DEC_RD_WAIT, DEC_RD_STREAM, DEC_SWALLOW, DEC_IGNORE
  } dec_state_e;

  typedef enum logic [2:0] {
    STB_IDLE, STB_WSETUP, STB_WLOW, STB_WHOLD, STB_RLOW
  } stb_state_e;

  // turnaround bytes between a read command and the first returned byte
  function automatic logic [TURN_W-1:0] turnaround_bytes(input byte_t op);
    return (op == 8'(OP_NAND_RD_FAST)) ? TURN_W'(4) : TURN_W'(1);
  endfunction

  function automatic logic is_read_op(input byte_t op);
    return (op == 8'(OP_NAND_RD)) || (op == 8'(OP_NAND_RD_FAST));
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/spi_nand_shifter.sv
module spi_nand_shifter #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  input  logic              tx_load,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              spi_miso,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_byte,
  output logic              frame_active
);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [SYNC_STAGES-1:0] sck_pipe, cs_pipe, mosi_pipe;
  logic                   sck_prev;
  logic [CNT_W-1:0]       bit_cnt;
  logic [DATA_W-1:0]      rx_sh, tx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_pipe  <= '0;
      cs_pipe   <= '1;
      mosi_pipe <= '0;
      sck_prev  <= 1'b0;
    end else begin
      sck_pipe  <= {sck_pipe[SYNC_STAGES-2:0], spi_sck};
      cs_pipe   <= {cs_pipe[SYNC_STAGES-2:0], spi_cs_n};
      mosi_pipe <= {mosi_pipe[SYNC_STAGES-2:0], spi_mosi};
      sck_prev  <= sck_pipe[SYNC_STAGES-1];
    end
  end

  wire sck_s  = sck_pipe[SYNC_STAGES-1];
  wire mosi_s = mosi_pipe[SYNC_STAGES-1];
  assign frame_active = ~cs_pipe[SYNC_STAGES-1];

  wire sck_rise = frame_active & sck_s & ~sck_prev;
  wire sck_fall = frame_active & ~sck_s & sck_prev;
  wire [DATA_W-1:0] rx_next = {rx_sh[DATA_W-2:0], mosi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      rx_sh    <= '0;
      rx_valid <= 1'b0;
      rx_byte  <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (!frame_active) begin
        bit_cnt <= '0;
        rx_sh   <= '0;
      end else if (sck_rise) begin
        rx_sh <= rx_next;
        if (bit_cnt == LAST_BIT) begin
          bit_cnt  <= '0;
          rx_valid <= 1'b1;
          rx_byte  <= rx_next;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  // output side: shift only inside a byte, so a loaded byte waits for the next one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       tx_sh <= '0;
    else if (!frame_active)           tx_sh <= '0;
    else if (tx_load)                 tx_sh <= tx_byte;
    else if (sck_fall && bit_cnt != '0) tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
  end

  assign spi_miso = tx_sh[DATA_W-1];
endmodule

// File: rtl/spi_nand_decoder.sv
module spi_nand_decoder
  import spi_nand_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  frame_active,
  input  logic  rx_valid,
  input  byte_t rx_byte,
  output byte_t ctl_q,
  output logic  led_aux,
  output logic  wr_start,
  output byte_t wr_byte,
  output logic  rd_start,
  output logic  ign_active
);
  dec_state_e          state;
  logic [TURN_W-1:0]   turn_left;
  byte_t               held;
  logic                held_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= DEC_OPCODE;
      turn_left <= '0;
      held      <= '0;
      held_v    <= 1'b0;
      ctl_q     <= CTL_RESET;
      led_aux   <= 1'b0;
      wr_start  <= 1'b0;
      wr_byte   <= '0;
      rd_start  <= 1'b0;
    end else begin
      wr_start <= 1'b0;
      rd_start <= 1'b0;
      if (!frame_active) begin
        state  <= DEC_OPCODE;
        held_v <= 1'b0;
      end else if (rx_valid) begin
        unique case (state)
          DEC_OPCODE: begin
            if (rx_byte == 8'(OP_CFG_WR)) state <= DEC_CFG;
            else if (rx_byte == 8'(OP_AUX_ON)) begin
              led_aux <= 1'b1;
              state   <= DEC_SWALLOW;
            end else if (rx_byte == 8'(OP_AUX_OFF)) begin
              led_aux <= 1'b0;
              state   <= DEC_SWALLOW;
            end else if (rx_byte == 8'(OP_NAND_WR)) begin
              held_v <= 1'b0;
              state  <= DEC_WRITE;
            end else if (is_read_op(rx_byte)) begin
              turn_left <= turnaround_bytes(rx_byte);
              state     <= DEC_RD_WAIT;
            end else begin
              state <= DEC_IGNORE;
            end
          end
          DEC_CFG: ctl_q <= rx_byte;
          DEC_WRITE: begin
            if (held_v) begin
              wr_start <= 1'b1;
              wr_byte  <= held;
            end
            held   <= rx_byte;
            held_v <= 1'b1;
          end
          DEC_RD_WAIT: begin
            if (turn_left == TURN_W'(1)) begin
              rd_start <= 1'b1;
              state    <= DEC_RD_STREAM;
            end else begin
              turn_left <= turn_left - 1'b1;
            end
          end
          DEC_RD_STREAM: rd_start <= 1'b1;
          DEC_SWALLOW, DEC_IGNORE: ;
          default: state <= DEC_IGNORE;
        endcase
      end
    end
  end

  assign ign_active = (state == DEC_IGNORE);
endmodule

// File: rtl/spi_nand_strobe.sv
module spi_nand_strobe
  import spi_nand_pkg::*;
#(
  parameter int unsigned WE_LOW_CYCLES = 2,
  parameter int unsigned RE_LOW_CYCLES = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_start,
  input  byte_t wr_data,
  input  logic  rd_start,
  input  byte_t nand_din,
  output logic  nand_we_n,
  output logic  nand_re_n,
  output byte_t nand_dout,
  output logic  nand_oe,
  output logic  rd_load,
  output byte_t rd_data
);
  localparam int unsigned CNT_W = $clog2(max_u(WE_LOW_CYCLES, RE_LOW_CYCLES) + 1);
  localparam logic [CNT_W-1:0] WE_LAST = CNT_W'(WE_LOW_CYCLES - 1);
  localparam logic [CNT_W-1:0] RE_LAST = CNT_W'(RE_LOW_CYCLES - 1);

  stb_state_e       state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= STB_IDLE;
      cnt       <= '0;
      nand_we_n <= 1'b1;
      nand_re_n <= 1'b1;
      nand_dout <= '0;
      nand_oe   <= 1'b0;
      rd_load   <= 1'b0;
      rd_data   <= '0;
    end else begin
      rd_load <= 1'b0;
      unique case (state)
        STB_IDLE: begin
          if (wr_start) begin
            nand_dout <= wr_data;
            nand_oe   <= 1'b1;
            state     <= STB_WSETUP;
          end else if (rd_start) begin
            nand_re_n <= 1'b0;
            cnt       <= '0;
            state     <= STB_RLOW;
          end
        end
        STB_WSETUP: begin
          nand_we_n <= 1'b0;
          cnt       <= '0;
          state     <= STB_WLOW;
        end
        STB_WLOW: begin
          cnt <= cnt + 1'b1;
          if (cnt == WE_LAST) begin
            nand_we_n <= 1'b1;
            state     <= STB_WHOLD;
          end
        end
        STB_WHOLD: begin
          nand_oe <= 1'b0;
          state   <= STB_IDLE;
        end
        STB_RLOW: begin
          cnt <= cnt + 1'b1;
          if (cnt == RE_LAST) begin
            nand_re_n <= 1'b1;
            rd_data   <= nand_din;
            rd_load   <= 1'b1;
            state     <= STB_IDLE;
          end
        end
        default: state <= STB_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_nand_bridge.sv
module spi_nand_bridge
  import spi_nand_pkg::*;
#(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned WE_LOW_CYCLES = 2,
  parameter int unsigned RE_LOW_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_sck,
  input  logic        spi_cs_n,
  input  logic        spi_mosi,
  output logic        spi_miso,
  input  logic [7:0]  nand_data_i,
  output logic [7:0]  nand_data_o,
  output logic        nand_data_oe,
  output logic        nand_we_n,
  output logic        nand_re_n,
  output logic        nand_ale,
  output logic        nand_cle,
  output logic        nand_ce_n,
  output logic [3:0]  led_o,
  output logic        fan_en,
  output logic        led_aux
);
  logic  rx_valid, frame_active, rd_load;
  byte_t rx_byte, rd_data, ctl_q, wr_byte;
  logic  wr_start, rd_start, ign_active;

  spi_nand_shifter #(.DATA_W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)) u_shift (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .tx_load(rd_load), .tx_byte(rd_data),
    .spi_miso(spi_miso), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .frame_active(frame_active)
  );

  spi_nand_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .frame_active(frame_active), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .ctl_q(ctl_q), .led_aux(led_aux), .wr_start(wr_start),
    .wr_byte(wr_byte), .rd_start(rd_start), .ign_active(ign_active)
  );

  spi_nand_strobe #(.WE_LOW_CYCLES(WE_LOW_CYCLES), .RE_LOW_CYCLES(RE_LOW_CYCLES)) u_stb (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_data(wr_byte),
    .rd_start(rd_start), .nand_din(nand_data_i), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_dout(nand_data_o), .nand_oe(nand_data_oe),
    .rd_load(rd_load), .rd_data(rd_data)
  );

  assign led_o     = ctl_q[CTL_LAMP_LO +: CTL_LAMP_N];
  assign fan_en    = ctl_q[CTL_FAN];
  assign nand_ale  = ctl_q[CTL_ALE];
  assign nand_cle  = ctl_q[CTL_CLE];
  assign nand_ce_n = ctl_q[CTL_CE_N];
endmodule

// File: rtl/spi_nand_checker.sv
module spi_nand_checker #(
  parameter int unsigned WE_LOW_CYCLES = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       nand_we_n,
  input logic       nand_re_n,
  input logic       nand_data_oe,
  input logic [7:0] nand_data_o,
  input logic       nand_ce_n,
  input logic       led_aux,
  input logic       wr_start,
  input logic       rd_start,
  input logic       ign_active,
  input logic       frame_active
);
  logic [7:0] we_low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         we_low_run <= '0;
    else if (!nand_we_n) we_low_run <= (we_low_run == 8'hFF) ? we_low_run : we_low_run + 1'b1;
    else                we_low_run <= '0;
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (nand_ce_n && !led_aux && nand_we_n && nand_re_n && !nand_data_oe));

  assert_we_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_we_n) |-> (we_low_run >= 8'(WE_LOW_CYCLES)));

  assert_we_data_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |=> ($stable(nand_data_o) && nand_data_oe));

  assert_oe_with_we_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> nand_data_oe);

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  assert_ignore_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ign_active |-> (!wr_start && !rd_start));

  assert_frame_resync_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_active |=> !ign_active);
endmodule

bind spi_nand_bridge spi_nand_checker #(.WE_LOW_CYCLES(WE_LOW_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
  .nand_data_oe(nand_data_oe), .nand_data_o(nand_data_o), .nand_ce_n(nand_ce_n),
  .led_aux(led_aux), .wr_start(wr_start), .rd_start(rd_start),
  .ign_active(ign_active), .frame_active(frame_active)
);

// File: tb/sim_spi_nand_bridge.sv
module sim_spi_nand_bridge;
  localparam int HALF = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  wire  miso;
  logic [7:0] nand_di;
  wire  [7:0] nand_do;
  wire  nand_oe, we_n, re_n, ale, cle, ce_n, fan, aux;
  wire  [3:0] leds;

  always #5 clk = ~clk;

  spi_nand_bridge u0 (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .nand_data_i(nand_di), .nand_data_o(nand_do),
    .nand_data_oe(nand_oe), .nand_we_n(we_n), .nand_re_n(re_n), .nand_ale(ale),
    .nand_cle(cle), .nand_ce_n(ce_n), .led_o(leds), .fan_en(fan), .led_aux(aux)
  );

  int n_chk = 0, n_fail = 0;
  int wr_cnt = 0, rd_idx = 0, low_run = 0, low_min = 99;
  logic [7:0] wr_log [16];
  logic oe_at_rise = 1'b0;
  bit done = 0;

  function automatic logic [7:0] rd_src(int k);
    return 8'hC3 ^ 8'(k * 29);
  endfunction

  assign nand_di = rd_src(rd_idx);

  always @(posedge we_n) if (rst_n) begin
    wr_log[wr_cnt % 16] = nand_do;
    oe_at_rise = nand_oe;
    wr_cnt++;
  end
  always @(posedge re_n) if (rst_n) rd_idx++;
  always @(posedge clk) if (rst_n) begin
    if (!we_n) low_run++;
    else begin
      if (low_run != 0 && low_run < low_min) low_min = low_run;
      low_run = 0;
    end
  end

  // {payload, expected {led_o, fan_en, ale, cle, ce_n}}
  localparam logic [15:0] CTL_VEC [8] = '{
    {8'h00, 8'b0000_0000}, {8'h80, 8'b0000_0001}, {8'h0F, 8'b1111_0000},
    {8'h10, 8'b0000_1000}, {8'h20, 8'b0000_0100}, {8'h40, 8'b0000_0010},
    {8'h5A, 8'b1010_1010}, {8'hA5, 8'b0101_0101}
  };

  function automatic logic [7:0] pins();
    return {leds, fan, ale, cle, ce_n};
  endfunction

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < nbits; i++) begin
      mosi = tx[7-i];
      wait_clk(HALF);
      rx = {rx[6:0], miso};
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    spi_bits(tx, 8, rx);
  endtask

  task automatic cs_lo();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic cs_hi();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(4 * HALF);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] rx;
    int wbase, rbase;
    wait_clk(5);
    // R1: reset values
    chk("R1 ctl pins", 32'(pins()), 32'h01);
    chk("R1 aux lamp", 32'(aux), 0);
    chk("R1 we_n", 32'(we_n), 1);
    chk("R1 re_n", 32'(re_n), 1);
    chk("R8 oe at reset", 32'(nand_oe), 0);
    rst_n = 1'b1;
    wait_clk(5);
    chk("R1 ctl after release", 32'(pins()), 32'h01);

    // R2: control byte vector table
    foreach (CTL_VEC[i]) begin
      cs_lo();
      xfer(8'h09, rx);
      xfer(CTL_VEC[i][15:8], rx);
      cs_hi();
      chk($sformatf("R2 vector %0d", i), 32'(pins()), 32'(CTL_VEC[i][7:0]));
    end

    // R2: several bytes in one frame, last one wins (0x22)
    cs_lo(); xfer(8'h09, rx); xfer(8'h11, rx); xfer(8'h22, rx); cs_hi();
    chk("R2 last byte wins", 32'(pins()), 32'h24);

    // R3: aux lamp on/off, payload ignored
    cs_lo(); xfer(8'h0C, rx); xfer(8'h09, rx); xfer(8'h55, rx); cs_hi();
    chk("R3 aux on", 32'(aux), 1);
    chk("R3 payload ignored", 32'(pins()), 32'h24);
    cs_lo(); xfer(8'h0D, rx); cs_hi();
    chk("R3 aux off", 32'(aux), 0);

    // R9: unknown command swallows the frame
    wbase = wr_cnt; rbase = rd_idx;
    cs_lo();
    xfer(8'h3C, rx); xfer(8'h09, rx); xfer(8'hFF, rx); xfer(8'h0C, rx);
    xfer(8'h08, rx); xfer(8'hAA, rx); xfer(8'hBB, rx);
    cs_hi();
    chk("R9 ctl unchanged", 32'(pins()), 32'h24);
    chk("R9 aux unchanged", 32'(aux), 0);
    chk("R9 no writes", 32'(wr_cnt - wbase), 0);
    chk("R9 no reads", 32'(rd_idx - rbase), 0);

    // R4/R5: write stream closed by an idle byte
    wbase = wr_cnt;
    cs_lo(); xfer(8'h08, rx); xfer(8'hA5, rx); xfer(8'h3C, rx); xfer(8'h00, rx); cs_hi();
    chk("R4 write count", 32'(wr_cnt - wbase), 2);
    chk("R4 first byte", 32'(wr_log[wbase % 16]), 32'hA5);
    chk("R4 second byte", 32'(wr_log[(wbase + 1) % 16]), 32'h3C);
    chk("R5 strobe width", 32'(low_min >= 2), 1);
    chk("R5 oe at strobe rise", 32'(oe_at_rise), 1);
    chk("R8 oe released", 32'(nand_oe), 0);

    // R4: frame cut after one data byte writes nothing
    wbase = wr_cnt;
    cs_lo(); xfer(8'h08, rx); xfer(8'h77, rx); cs_hi();
    chk("R4 unflushed byte dropped", 32'(wr_cnt - wbase), 0);

    // R6: normal read, one turnaround byte
    rbase = rd_idx; wbase = wr_cnt;
    cs_lo(); xfer(8'h0A, rx);
    wait_clk(2 * HALF);
    chk("R6 no read before turnaround", 32'(rd_idx - rbase), 0);
    xfer(8'h00, rx);
    xfer(8'h00, rx); chk("R6 read byte 0", 32'(rx), 32'(rd_src(rbase)));
    xfer(8'h00, rx); chk("R6 read byte 1", 32'(rx), 32'(rd_src(rbase + 1)));
    xfer(8'h00, rx); chk("R6 read byte 2", 32'(rx), 32'(rd_src(rbase + 2)));
    cs_hi();
    chk("R6 read strobe count", 32'(rd_idx - rbase), 4);
    chk("R8 no write during read", 32'(wr_cnt - wbase), 0);

    // R7: fast read, four turnaround bytes
    rbase = rd_idx;
    cs_lo(); xfer(8'h0B, rx);
    xfer(8'h00, rx); xfer(8'h00, rx); xfer(8'h00, rx);
    wait_clk(2 * HALF);
    chk("R7 no read after three idles", 32'(rd_idx - rbase), 0);
    xfer(8'h00, rx);
    xfer(8'h00, rx); chk("R7 read byte 0", 32'(rx), 32'(rd_src(rbase)));
    xfer(8'h00, rx); chk("R7 read byte 1", 32'(rx), 32'(rd_src(rbase + 1)));
    cs_hi();

    // R10: partial byte dropped, next frame decodes fresh (0x4B)
    cs_lo(); spi_bits(8'hFF, 5, rx); cs_hi();
    cs_lo(); xfer(8'h09, rx); xfer(8'h4B, rx); cs_hi();
    chk("R10 resync after partial byte", 32'(pins()), 32'hB2);

    done = 1;
    summary();
    $finish;
  end
endmodule